// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block sends a command frame of 1 to 32 bits from a reader toward a card over one output line. Each bit becomes a symbol whose total length carries the information. A symbol opens with a short low pause and then returns high. Its overall length is long when the encoded bit is 1 and short when it is 0. Before a bit is encoded it is XORed with a keystream bit that arrives from outside the block. The block asks for the next keystream bit with a single-cycle step request during every symbol.

A frame starts with a start strobe that carries the frame value and the bit count. Bits go out least significant first. When the last symbol ends, the internal bit timer is cleared. A done pulse is raised while the timer reads zero. After that the timer keeps counting, one per cycle, on a timer output. A later stage can read this output to measure the gap until the card answers. Between frames the line rests high, which acts as the carrier. If the keystream input is held at zero, the frame goes out unencrypted.

Top module: `pp_bit_tx`

## Requirements
- R1: Frame bits go out least significant bit first, one symbol per bit. Symbol k encodes bit k of `frameData`.
- R2: The encoded value of symbol k is frame bit k XOR `ksBit`. `ksBit` is sampled at the clock edge that begins symbol k. Symbol length, counted from one falling edge of `lineOut` to the next (or to the `done` cycle), is ONE_CYC cycles for an encoded 1 and ZERO_CYC cycles for an encoded 0 (defaults 12 and 8).
- R3: Every symbol begins with `lineOut` low for exactly PAUSE_CYC cycles (default 4). The line is high for the rest of the symbol.
- R4: `ksStep` is a one-cycle pulse, raised exactly once per symbol. It comes in the first high cycle of the symbol, PAUSE_CYC cycles after the symbol starts.
- R5: `done` is a one-cycle pulse in the cycle right after the last cycle of the last symbol. In that cycle `bitTimer` reads 0. After it, `bitTimer` rises by one per cycle and saturates at its maximum.
- R6: With `ksBit` held at 0, every symbol length follows the plain frame bit.
- R7: A `start` pulse that arrives while a frame is in progress is ignored. The running frame is unchanged and no second frame follows.
- R8: A `bitCount` of 0 raises `done` in the cycle after `start` is sampled. The line never goes low and `ksStep` is never raised.
- R9: After reset and between frames, `lineOut` is high and both `done` and `ksStep` are low.
- R10: A `bitCount` above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken only while idle) |
| frameData | input | 32 | Frame value, bit 0 is sent first |
| bitCount | input | 6 | Number of bits to send, 0 to 32 |
| ksBit | input | 1 | Current keystream bit |
| ksStep | output | 1 | Request to advance the keystream by one |
| lineOut | output | 1 | Pulse-pause encoded line, idle high |
| done | output | 1 | Frame finished pulse |
| bitTimer | output | 12 | Symbol timer; after a frame, cycles since done |

## Verification
The hardest case is a keystream that changes inside a frame. The value used for each symbol must be the one present after the previous step request, not the one present at `start`. To reach it, the bench models a keystream source that moves through a fixed pattern on every `ksStep`. It then checks each recorded symbol length against the frame bit XOR the pattern bit at the same index. A second stimulus that is hard to reach is a `start` pulse in the middle of a frame. The bench raises it with different data and count while symbols are on the line. It then watches the line for many idle cycles to confirm that no extra frame appears.

// File: rtl/pp_bit_tx_pkg.sv
package pp_bit_tx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture frame, count, first encoded bit
    logic advance;   // end of symbol: shift and fetch next encoded bit
    logic clrTimer;  // zero the bit timer without touching the frame
  } ppStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYM,
    ST_FIN
  } ppState_t;
endpackage

// File: rtl/pp_bit_tx_dp.sv
module pp_bit_tx_dp
  import pp_bit_tx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 6,
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  ppStrobe_t          strb,
  input  logic [DATA_W-1:0]  frameIn,
  input  logic [CNT_W-1:0]   countIn,
  input  logic               ksBit,
  output logic [CNT_W-1:0]   leftCnt,
  output logic [TIMER_W-1:0] bitTimer,
  output logic               encBit
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DATA_W);

  logic [DATA_W-1:0]  shiftQ;
  logic [CNT_W-1:0]   leftQ;
  logic [TIMER_W-1:0] timerQ;
  logic               encQ;
  logic [CNT_W-1:0]   countClamped;

  assign countClamped = (countIn > MAX_CNT) ? MAX_CNT : countIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      leftQ  <= '0;
      timerQ <= '0;
      encQ   <= 1'b0;
    end else if (strb.load) begin
      shiftQ <= frameIn;
      leftQ  <= countClamped;
      timerQ <= '0;
      encQ   <= frameIn[0] ^ ksBit;
    end else if (strb.advance) begin
      shiftQ <= shiftQ >> 1;
      leftQ  <= leftQ - 1'b1;
      timerQ <= '0;
      encQ   <= shiftQ[1] ^ ksBit;
    end else if (strb.clrTimer) begin
      timerQ <= '0;
    end else if (timerQ != '1) begin
      timerQ <= timerQ + 1'b1;
    end
  end

  assign leftCnt  = leftQ;
  assign bitTimer = timerQ;
  assign encBit   = encQ;

  // R5: timer saturates instead of wrapping
  assert_timer_saturates_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(timerQ) == '1 && !strb.load && !strb.advance && !strb.clrTimer) |-> timerQ == '1);

  // R10: the remaining count never exceeds the frame width
  assert_count_clamped_R10: assert property (@(posedge clk) disable iff (!rstN)
    leftQ <= MAX_CNT);
endmodule

// File: rtl/pp_bit_tx_ctrl.sv
module pp_bit_tx_ctrl
  import pp_bit_tx_pkg::*;
#(
  parameter int PAUSE_CYC = 4,
  parameter int ONE_CYC   = 12,
  parameter int ZERO_CYC  = 8,
  parameter int CNT_W     = 6,
  parameter int TIMER_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   countIn,
  input  logic [CNT_W-1:0]   leftCnt,
  input  logic [TIMER_W-1:0] bitTimer,
  input  logic               encBit,
  output ppStrobe_t          strb,
  output logic               lineOut,
  output logic               ksStep,
  output logic               done
);
  localparam logic [TIMER_W-1:0] PAUSE_T    = TIMER_W'(PAUSE_CYC);
  localparam logic [TIMER_W-1:0] ONE_LAST   = TIMER_W'(ONE_CYC - 1);
  localparam logic [TIMER_W-1:0] ZERO_LAST  = TIMER_W'(ZERO_CYC - 1);
  localparam logic [CNT_W-1:0]   ONE_LEFT   = CNT_W'(1);

  ppState_t st, stNext;
  logic     symLast;

  assign symLast = (bitTimer == (encBit ? ONE_LAST : ZERO_LAST));

  always_comb begin
    strb   = '0;
    stNext = st;
    case (st)
      ST_IDLE: begin
        if (start) begin
          if (countIn == '0) begin
            strb.clrTimer = 1'b1;
            stNext        = ST_FIN;
          end else begin
            strb.load = 1'b1;
            stNext    = ST_SYM;
          end
        end
      end
      ST_SYM: begin
        if (symLast) begin
          strb.advance = 1'b1;
          if (leftCnt == ONE_LEFT) stNext = ST_FIN;
        end
      end
      ST_FIN:  stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  assign lineOut = !((st == ST_SYM) && (bitTimer < PAUSE_T));
  assign ksStep  = (st == ST_SYM) && (bitTimer == PAUSE_T);
  assign done    = (st == ST_FIN);

  // R4: step request falls in the high part and lasts one cycle
  assert_step_in_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    ksStep |-> lineOut);
  assert_step_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    ksStep |=> !ksStep);

  // R5: done is a single pulse seen while the timer reads zero
  assert_done_timer_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (bitTimer == '0));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: line is high when a frame completes
  assert_done_line_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> lineOut);

  // R7: a frame in progress is never restarted by load
  assert_no_reload_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE) |-> !strb.load);
endmodule

// File: rtl/pp_bit_tx.sv
module pp_bit_tx
  import pp_bit_tx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PAUSE_CYC = 4,
  parameter int ONE_CYC   = 12,
  parameter int ZERO_CYC  = 8,
  parameter int TIMER_W   = 12,
  localparam int CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [DATA_W-1:0]  frameData,
  input  logic [CNT_W-1:0]   bitCount,
  input  logic               ksBit,
  output logic               ksStep,
  output logic               lineOut,
  output logic               done,
  output logic [TIMER_W-1:0] bitTimer
);
  ppStrobe_t        strb;
  logic [CNT_W-1:0] leftCnt;
  logic             encBit;

  pp_bit_tx_ctrl #(
    .PAUSE_CYC(PAUSE_CYC), .ONE_CYC(ONE_CYC), .ZERO_CYC(ZERO_CYC),
    .CNT_W(CNT_W), .TIMER_W(TIMER_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .countIn(bitCount),
    .leftCnt(leftCnt), .bitTimer(bitTimer), .encBit(encBit),
    .strb(strb), .lineOut(lineOut), .ksStep(ksStep), .done(done)
  );

  pp_bit_tx_dp #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .TIMER_W(TIMER_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .frameIn(frameData),
    .countIn(bitCount), .ksBit(ksBit), .leftCnt(leftCnt),
    .bitTimer(bitTimer), .encBit(encBit)
  );
endmodule

// File: tb/sim_pp_bit_tx.sv
`timescale 1ns/1ps
module sim_pp_bit_tx;
  localparam int PAUSE = 4;
  localparam int ONE   = 12;
  localparam int ZERO  = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] frameData = '0;
  logic [5:0]  bitCount = '0;
  logic        ksBit;
  logic        ksStep, lineOut, done;
  logic [11:0] bitTimer;

  logic [63:0] ksPat = '0;
  logic [6:0]  ksIdx = '0;
  logic        ksRst = 1'b1;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (ksRst)       ksIdx <= '0;
    else if (ksStep) ksIdx <= ksIdx + 1'b1;
  end
  assign ksBit = ksPat[ksIdx[5:0]];

  pp_bit_tx u0 (
    .clk(clk), .rstN(rstN), .start(start), .frameData(frameData),
    .bitCount(bitCount), .ksBit(ksBit), .ksStep(ksStep),
    .lineOut(lineOut), .done(done), .bitTimer(bitTimer)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Send one frame and check timing of every symbol
  task automatic runFrame(input logic [31:0] data, input logic [5:0] cnt,
                          input logic [63:0] pat, input bit poke,
                          input string req);
    int eff, nSym, symStart, doneT, steps, stepBad, lowBad, expDone;
    int lens[41];
    int badIdx, badAct, badExp, timerAtDone;
    bit prev;
    eff = (cnt > 32) ? 32 : int'(cnt);
    @(negedge clk);
    frameData = data; bitCount = cnt; ksPat = pat; ksRst = 1'b1;
    @(negedge clk);
    ksRst = 1'b0; start = 1'b1;
    nSym = 0; symStart = 0; doneT = 0; steps = 0; stepBad = 0; lowBad = 0;
    timerAtDone = -1; prev = 1'b1;
    for (int t = 1; t <= 3000 && doneT == 0; t++) begin
      @(negedge clk);
      if (prev && !lineOut) begin
        if (nSym > 0 && nSym <= 41) lens[nSym-1] = t - symStart;
        symStart = t;
        nSym++;
      end
      if (!prev && lineOut && (t - symStart) != PAUSE) lowBad++;
      if (ksStep) begin
        steps++;
        if (nSym == 0 || (t - symStart) != PAUSE) stepBad++;
      end
      if (done) begin
        doneT = t;
        timerAtDone = int'(bitTimer);
        if (nSym > 0 && nSym <= 41) lens[nSym-1] = t - symStart;
      end
      prev = lineOut;
      if (t == 1) start = 1'b0;
      if (poke && t == 5) begin start = 1'b1; frameData = ~data; bitCount = 6'd3; end
      if (poke && t == 6) start = 1'b0;
    end
    chk(nSym == eff, req, "symbol count", nSym, eff);
    badIdx = -1; badAct = 0; badExp = 0; expDone = 1;
    for (int i = 0; i < eff; i++) begin
      int e;
      e = (data[i] ^ pat[i]) ? ONE : ZERO;
      expDone += e;
      if (badIdx < 0 && i < nSym && lens[i] != e) begin
        badIdx = i; badAct = lens[i]; badExp = e;
      end
    end
    chk(badIdx < 0, req, $sformatf("symbol length at bit %0d", badIdx), badAct, badExp);
    chk(lowBad == 0, "R3", "pause length errors", lowBad, 0);
    chk(steps == eff && stepBad == 0, "R4", "keystream steps", steps, eff);
    chk(doneT == expDone, "R5", "done cycle", doneT, expDone);
    chk(timerAtDone == 0, "R5", "timer at done", timerAtDone, 0);
  endtask

  task automatic checkGap();
    repeat (5) @(negedge clk);
    chk(bitTimer == 12'd5, "R5", "timer five cycles after done", int'(bitTimer), 5);
  endtask

  task automatic checkIdle(input string req, input int cycles);
    int lows, dones, steps;
    lows = 0; dones = 0; steps = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!lineOut) lows++;
      if (done) dones++;
      if (ksStep) steps++;
    end
    chk(lows == 0 && dones == 0 && steps == 0, req, "idle activity", lows + dones + steps, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(lineOut == 1'b1, "R9", "line after reset", lineOut, 1);
    chk(done == 1'b0, "R9", "done after reset", done, 0);
    chk(ksStep == 1'b0, "R9", "step after reset", ksStep, 0);
  endtask

  task automatic testPlain();       // R1 R6
    runFrame(32'h0000_00A5, 6'd8, 64'h0, 1'b0, "R6");
    runFrame(32'h0000_0001, 6'd7, 64'h0, 1'b0, "R1");
    checkGap();
  endtask

  task automatic testEncrypted();   // R2
    runFrame(32'h1234_5678, 6'd32, 64'h0000_0001_DEAD_BEEF, 1'b0, "R2");
    runFrame(32'hFFFF_FFFF, 6'd16, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R2");
    runFrame(32'h0000_0001, 6'd1, 64'h0, 1'b0, "R1");
  endtask

  task automatic testZero();        // R8
    runFrame(32'hFFFF_FFFF, 6'd0, 64'h0, 1'b0, "R8");
  endtask

  task automatic testBusy();        // R7
    runFrame(32'h0000_0C3A, 6'd12, 64'h0000_0000_0000_0F0F, 1'b1, "R7");
    checkIdle("R7", 60);
  endtask

  task automatic testClamp();       // R10
    runFrame(32'hA5A5_0F0F, 6'd40, 64'h3, 1'b0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    checkIdle("R9", 20);
    testPlain();
    testEncrypted();
    testZero();
    testBusy();
    testClamp();
    checkIdle("R9", 10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule